// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block holds the operating mode of a small microcontroller and turns it into the enable lines for that chip's clocks, oscillators, core regulator, RAM power and I/O pad latches. Software picks a mode by writing a three-bit code while the CPU is running. From then on, the block alone decides which clocks stay alive, and it decides how the device comes back out of that mode.

Six modes are resumable sleeps: active and five standby levels, each switching off more of the clock tree. An interrupt entry saves the current mode and forces active mode. A return-from-interrupt strobe puts the saved mode back, unless the handler has asked to stay awake. Leaving a standby level that stopped the main oscillator costs a settling delay. The delay is a parameter, and the CPU clock enable stays low until it has passed. The two shutdown modes drop the core regulator and main RAM. They ignore ordinary interrupts and leave only through a small set of wake events. Leaving them is a restart: the block pulses a system reset request and sets a sticky shutdown-exit flag.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode is active (code 0), the CPU clock enable is high, and the handler flag, shutdown-exit flag and reset request are all low.
- R2: The mode codes are 0 active, 1 to 5 standby levels S0 to S4, 6 shutdown-with-clock, 7 deep shutdown. Enables per code, listed as cpu,per,aux,fll,osc,dc,xtal,reg,ram,pad,rtc: 0=11111111101, 1=01111111101, 2=01101111101, 3=00100111101, 4=00100011101, 5=00000001100, 6=00000010011, 7=00000000010. The CPU clock enable is never high outside code 0.
- R3: A mode request is taken only when the mode is active, the CPU clock enable is high and no handler is in progress. In every other case it has no effect.
- R4: An interrupt entry in code 0 to 5 with no handler in progress stores the current mode, sets the handler flag and forces code 0 on the next cycle.
- R5: After a change to active mode from code 3, 4 or 5, or after a shutdown exit, the CPU clock enable stays low for exactly WAKE_CYC cycles. From code 0, 1 or 2 it is high in the first cycle in active mode.
- R6: A return strobe during a handler restores the stored mode and clears the handler flag.
- R7: A stay-awake strobe during a handler replaces the stored mode with active, so the following return leaves the device in code 0.
- R8: An interrupt entry has no effect while a handler is in progress or in code 6 or 7.
- R9: Code 6 exits on the reset/NMI, timer or port wake input. Code 7 exits on reset/NMI or port only, and the timer wake input has no effect in code 7.
- R10: A shutdown exit goes to code 0 with no handler pending, raises the reset request for exactly one cycle, and sets the shutdown-exit flag. The flag then stays high until the block reset.
- R11: The three wake inputs have no effect outside codes 6 and 7.
- R12: A return strobe has no effect when no handler is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req_vld | input | 1 | Software mode write strobe |
| mode_req | input | 3 | Requested mode code |
| irq_enter | input | 1 | Interrupt entry strobe |
| irq_return | input | 1 | Return-from-interrupt strobe |
| stay_awake | input | 1 | Handler request to stay in active mode after return |
| wake_rst | input | 1 | Reset/NMI pin wake event |
| wake_rtc | input | 1 | Real-time-clock wake event |
| wake_port | input | 1 | Port 1/2 wake event |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral subsystem clock enable |
| aux_clk_en | output | 1 | Auxiliary clock enable |
| fll_en | output | 1 | Frequency-locked-loop control enable |
| osc_clk_en | output | 1 | Main oscillator clock enable |
| osc_dc_en | output | 1 | Main oscillator dc generator enable |
| xtal_en | output | 1 | Crystal oscillator enable |
| core_reg_en | output | 1 | Core regulator enable |
| ram_pwr_en | output | 1 | Main RAM power/retention enable |
| pad_hold | output | 1 | I/O pad state latch |
| rtc_en | output | 1 | Real-time-clock run enable |
| sys_reset_req | output | 1 | One-cycle restart request on shutdown exit |
| shutdown_exit | output | 1 | Sticky flag: last wake came from shutdown |
| in_handler | output | 1 | Interrupt handler in progress |
| pm_mode | output | 3 | Current mode code |

## Verification
The bench builds the block with WAKE_CYC set to 3. With that setting, the settling window after each slow wake can be walked one cycle at a time, checking that the CPU clock enable stays low and then rises on the exact cycle. At this size the sweep reaches every standby code through request, entry and return, and every pairing of shutdown code with wake source. It also reaches the case where a request arrives while the settling window is still open.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    PM_ACT  = 3'd0,
    PM_S0   = 3'd1,
    PM_S1   = 3'd2,
    PM_S2   = 3'd3,
    PM_S3   = 3'd4,
    PM_S4   = 3'd5,
    PM_SDC  = 3'd6,
    PM_SDD  = 3'd7
  } pm_mode_e;

  typedef struct packed {
    logic cpu;
    logic per;
    logic aux;
    logic fll;
    logic osc;
    logic dc;
    logic xtal;
    logic core_reg;
    logic ram;
    logic pad_hold;
    logic rtc;
  } pm_en_t;

  function automatic logic slow_wake(pm_mode_e m);
    return (m == PM_S2) || (m == PM_S3) || (m == PM_S4);
  endfunction

  function automatic logic is_shutdown(pm_mode_e m);
    return (m == PM_SDC) || (m == PM_SDD);
  endfunction
endpackage

// File: rtl/pmc_mode_decode.sv
module pmc_mode_decode
  import pmc_pkg::*;
(
  input  pm_mode_e mode,
  output pm_en_t   en
);
  always_comb begin
    en = '0;
    unique case (mode)
      PM_ACT: begin
        en.cpu = 1'b1; en.per = 1'b1; en.aux = 1'b1; en.fll = 1'b1;
        en.osc = 1'b1; en.dc = 1'b1; en.xtal = 1'b1; en.core_reg = 1'b1;
        en.ram = 1'b1; en.rtc = 1'b1;
      end
      PM_S0: begin
        en.per = 1'b1; en.aux = 1'b1; en.fll = 1'b1;
        en.osc = 1'b1; en.dc = 1'b1; en.xtal = 1'b1; en.core_reg = 1'b1;
        en.ram = 1'b1; en.rtc = 1'b1;
      end
      PM_S1: begin
        en.per = 1'b1; en.aux = 1'b1;
        en.osc = 1'b1; en.dc = 1'b1; en.xtal = 1'b1; en.core_reg = 1'b1;
        en.ram = 1'b1; en.rtc = 1'b1;
      end
      PM_S2: begin
        en.aux = 1'b1; en.dc = 1'b1; en.xtal = 1'b1; en.core_reg = 1'b1;
        en.ram = 1'b1; en.rtc = 1'b1;
      end
      PM_S3: begin
        en.aux = 1'b1; en.xtal = 1'b1; en.core_reg = 1'b1;
        en.ram = 1'b1; en.rtc = 1'b1;
      end
      PM_S4: begin
        en.core_reg = 1'b1; en.ram = 1'b1;
      end
      PM_SDC: begin
        en.xtal = 1'b1; en.pad_hold = 1'b1; en.rtc = 1'b1;
      end
      PM_SDD: begin
        en.pad_hold = 1'b1;
      end
      default: en = '0;
    endcase
  end
endmodule

// File: rtl/pmc_wake_timer.sv
module pmc_wake_timer #(
  parameter int WAKE_CYC = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = (WAKE_CYC < 1) ? 1 : $clog2(WAKE_CYC + 1);

  generate
    if (WAKE_CYC == 0) begin : g_none
      assign busy = 1'b0;
    end else begin : g_cnt
      logic [CNT_W-1:0] cnt_q;
      logic [CNT_W-1:0] cnt_d;
      logic             cnt_en;

      always_comb begin
        cnt_en = start || (cnt_q != '0);
        cnt_d  = cnt_q;
        if (start)               cnt_d = CNT_W'(WAKE_CYC);
        else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_en) cnt_q <= cnt_d;
      end

      assign busy = (cnt_q != '0);

      assert_busy_after_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
      assert_count_drains_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> (cnt_q + 1'b1 == $past(cnt_q)));
    end
  endgenerate
endmodule

// File: rtl/pmc_seq.sv
module pmc_seq
  import pmc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_vld,
  input  pm_mode_e req_mode,
  input  logic     irq_enter,
  input  logic     irq_return,
  input  logic     stay_awake,
  input  logic     wake_rst,
  input  logic     wake_rtc,
  input  logic     wake_port,
  input  logic     cpu_run,
  output pm_mode_e cur_mode,
  output logic     in_isr,
  output logic     timer_start,
  output logic     rst_pulse,
  output logic     sd_flag
);
  pm_mode_e cur_q, cur_d, saved_q, saved_d;
  logic     isr_q, isr_d, rstp_q, rstp_d, flag_q, flag_d;
  logic     sd_wake;

  assign sd_wake = wake_rst || wake_port || ((cur_q == PM_SDC) && wake_rtc);

  always_comb begin
    cur_d       = cur_q;
    saved_d     = saved_q;
    isr_d       = isr_q;
    flag_d      = flag_q;
    rstp_d      = 1'b0;
    timer_start = 1'b0;
    if (is_shutdown(cur_q)) begin
      if (sd_wake) begin
        cur_d       = PM_ACT;
        saved_d     = PM_ACT;
        isr_d       = 1'b0;
        rstp_d      = 1'b1;
        flag_d      = 1'b1;
        timer_start = 1'b1;
      end
    end else if (isr_q) begin
      if (stay_awake) saved_d = PM_ACT;
      if (irq_return) begin
        cur_d = stay_awake ? PM_ACT : saved_q;
        isr_d = 1'b0;
      end
    end else if (irq_enter) begin
      saved_d     = cur_q;
      cur_d       = PM_ACT;
      isr_d       = 1'b1;
      timer_start = slow_wake(cur_q);
    end else if (req_vld && (cur_q == PM_ACT) && cpu_run) begin
      cur_d = req_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= PM_ACT;
      saved_q <= PM_ACT;
      isr_q   <= 1'b0;
      rstp_q  <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      cur_q   <= cur_d;
      saved_q <= saved_d;
      isr_q   <= isr_d;
      rstp_q  <= rstp_d;
      flag_q  <= flag_d;
    end
  end

  assign cur_mode  = cur_q;
  assign in_isr    = isr_q;
  assign rst_pulse = rstp_q;
  assign sd_flag   = flag_q;

  assert_irq_forces_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_enter && !isr_q && !is_shutdown(cur_q)) |=> (cur_q == PM_ACT && isr_q));
  assert_req_blocked_in_isr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && isr_q && !irq_return) |=> $stable(cur_q));
  assert_return_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_q && irq_return) |=> !isr_q);
  assert_deep_ignores_rtc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == PM_SDD && !wake_rst && !wake_port) |=> (cur_q == PM_SDD));
  assert_reset_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rstp_q |=> !rstp_q);
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |=> flag_q);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int WAKE_CYC = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_req_vld,
  input  logic [MODE_W-1:0] mode_req,
  input  logic              irq_enter,
  input  logic              irq_return,
  input  logic              stay_awake,
  input  logic              wake_rst,
  input  logic              wake_rtc,
  input  logic              wake_port,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              aux_clk_en,
  output logic              fll_en,
  output logic              osc_clk_en,
  output logic              osc_dc_en,
  output logic              xtal_en,
  output logic              core_reg_en,
  output logic              ram_pwr_en,
  output logic              pad_hold,
  output logic              rtc_en,
  output logic              sys_reset_req,
  output logic              shutdown_exit,
  output logic              in_handler,
  output logic [MODE_W-1:0] pm_mode
);
  pm_mode_e cur_mode;
  pm_en_t   en;
  logic     wake_busy, t_start, cpu_run;

  assign cpu_run = en.cpu && !wake_busy;

  pmc_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_vld     (mode_req_vld),
    .req_mode    (pm_mode_e'(mode_req)),
    .irq_enter   (irq_enter),
    .irq_return  (irq_return),
    .stay_awake  (stay_awake),
    .wake_rst    (wake_rst),
    .wake_rtc    (wake_rtc),
    .wake_port   (wake_port),
    .cpu_run     (cpu_run),
    .cur_mode    (cur_mode),
    .in_isr      (in_handler),
    .timer_start (t_start),
    .rst_pulse   (sys_reset_req),
    .sd_flag     (shutdown_exit)
  );

  pmc_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (t_start),
    .busy  (wake_busy)
  );

  pmc_mode_decode u_dec (
    .mode (cur_mode),
    .en   (en)
  );

  assign cpu_clk_en  = cpu_run;
  assign per_clk_en  = en.per;
  assign aux_clk_en  = en.aux;
  assign fll_en      = en.fll;
  assign osc_clk_en  = en.osc;
  assign osc_dc_en   = en.dc;
  assign xtal_en     = en.xtal;
  assign core_reg_en = en.core_reg;
  assign ram_pwr_en  = en.ram;
  assign pad_hold    = en.pad_hold;
  assign rtc_en      = en.rtc;
  assign pm_mode     = cur_mode;

  assert_cpu_dark_when_asleep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_mode != 3'd0) |-> !cpu_clk_en);
  assert_shutdown_reset_goes_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |-> (pm_mode == 3'd0 && !in_handler));
endmodule

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
  localparam int W = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic mode_req_vld, irq_enter, irq_return, stay_awake, wake_rst, wake_rtc, wake_port;
  logic [2:0] mode_req;
  logic cpu_clk_en, per_clk_en, aux_clk_en, fll_en, osc_clk_en, osc_dc_en, xtal_en;
  logic core_reg_en, ram_pwr_en, pad_hold, rtc_en, sys_reset_req, shutdown_exit, in_handler;
  logic [2:0] pm_mode;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl #(.WAKE_CYC(W)) i_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_req_vld(mode_req_vld), .mode_req(mode_req),
    .irq_enter(irq_enter), .irq_return(irq_return), .stay_awake(stay_awake),
    .wake_rst(wake_rst), .wake_rtc(wake_rtc), .wake_port(wake_port),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .aux_clk_en(aux_clk_en),
    .fll_en(fll_en), .osc_clk_en(osc_clk_en), .osc_dc_en(osc_dc_en), .xtal_en(xtal_en),
    .core_reg_en(core_reg_en), .ram_pwr_en(ram_pwr_en), .pad_hold(pad_hold),
    .rtc_en(rtc_en), .sys_reset_req(sys_reset_req), .shutdown_exit(shutdown_exit),
    .in_handler(in_handler), .pm_mode(pm_mode)
  );

  function automatic logic [10:0] exp_en(int m);
    case (m)
      0: return 11'b11111111101;
      1: return 11'b01111111101;
      2: return 11'b01101111101;
      3: return 11'b00100111101;
      4: return 11'b00100011101;
      5: return 11'b00000001100;
      6: return 11'b00000010011;
      default: return 11'b00000000010;
    endcase
  endfunction

  function automatic logic [10:0] got_en();
    return {cpu_clk_en, per_clk_en, aux_clk_en, fll_en, osc_clk_en, osc_dc_en,
            xtal_en, core_reg_en, ram_pwr_en, pad_hold, rtc_en};
  endfunction

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_inputs();
    mode_req_vld = 0; mode_req = 0; irq_enter = 0; irq_return = 0;
    stay_awake = 0; wake_rst = 0; wake_rtc = 0; wake_port = 0;
  endtask

  task automatic reset_dut();
    clear_inputs();
    rst_n = 0;
    tick(); tick();
    rst_n = 1;
    tick();
  endtask

  task automatic go_mode(int m);
    mode_req_vld = 1; mode_req = 3'(m);
    tick();
    mode_req_vld = 0;
    check("R3", "request accepted", pm_mode, m);
    check("R2", "enable set", got_en(), exp_en(m));
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    reset_dut();
    // R1: reset state
    check("R1", "mode", pm_mode, 0);
    check("R1", "cpu clock", cpu_clk_en, 1);
    check("R1", "handler", in_handler, 0);
    check("R1", "flag", shutdown_exit, 0);
    check("R1", "reset req", sys_reset_req, 0);
    check("R2", "active enables", got_en(), exp_en(0));

    // Standby codes 1..5: request, ignore cases, entry, wake delay, return
    for (int m = 1; m <= 5; m++) begin
      reset_dut();
      go_mode(m);
      // R11: wake inputs ignored outside shutdown
      wake_rst = 1; wake_rtc = 1; wake_port = 1;
      tick();
      wake_rst = 0; wake_rtc = 0; wake_port = 0;
      check("R11", "mode after wakes", pm_mode, m);
      check("R11", "no reset req", sys_reset_req, 0);
      // R12: return with no handler
      irq_return = 1;
      tick();
      irq_return = 0;
      check("R12", "mode after stray return", pm_mode, m);
      // R3: request while asleep
      mode_req_vld = 1; mode_req = 3'((m == 5) ? 1 : 5);
      tick();
      mode_req_vld = 0;
      check("R3", "request while asleep", pm_mode, m);
      // R4: interrupt entry
      irq_enter = 1;
      tick();
      irq_enter = 0;
      check("R4", "forced active", pm_mode, 0);
      check("R4", "handler set", in_handler, 1);
      // R5: wake delay
      if (m >= 3) begin
        check("R5", "cpu low at entry", cpu_clk_en, 0);
        for (int k = 1; k < W; k++) begin
          tick();
          check("R5", "cpu low in window", cpu_clk_en, 0);
        end
        tick();
      end
      check("R5", "cpu running", cpu_clk_en, 1);
      check("R2", "active enables", got_en(), exp_en(0));
      // R3: request during handler
      mode_req_vld = 1; mode_req = 3'd5;
      tick();
      mode_req_vld = 0;
      check("R3", "request in handler", pm_mode, 0);
      if (m % 2 == 1) begin
        // R7: stay awake then return
        stay_awake = 1;
        tick();
        stay_awake = 0;
        irq_return = 1;
        tick();
        irq_return = 0;
        check("R7", "stays active", pm_mode, 0);
        check("R7", "handler cleared", in_handler, 0);
      end else begin
        // R8: nested entry ignored, saved mode kept
        irq_enter = 1;
        tick();
        irq_enter = 0;
        check("R8", "still in handler", in_handler, 1);
        irq_return = 1;
        tick();
        irq_return = 0;
        check("R6", "restored mode", pm_mode, m);
        check("R6", "handler cleared", in_handler, 0);
        check("R2", "restored enables", got_en(), exp_en(m));
      end
    end

    // Shutdown codes x wake sources
    for (int m = 6; m <= 7; m++) begin
      for (int src = 0; src < 3; src++) begin
        if (m == 7 && src == 1) continue;
        reset_dut();
        go_mode(m);
        irq_enter = 1;
        tick();
        irq_enter = 0;
        check("R8", "entry ignored in shutdown", pm_mode, m);
        if (m == 7) begin
          wake_rtc = 1;
          tick();
          wake_rtc = 0;
          check("R9", "timer wake ignored in deep", pm_mode, 7);
          check("R9", "no reset req", sys_reset_req, 0);
        end
        wake_rst = (src == 0); wake_rtc = (src == 1); wake_port = (src == 2);
        tick();
        wake_rst = 0; wake_rtc = 0; wake_port = 0;
        check("R9", "exit to active", pm_mode, 0);
        check("R10", "reset req high", sys_reset_req, 1);
        check("R10", "flag set", shutdown_exit, 1);
        check("R10", "no handler", in_handler, 0);
        check("R5", "cpu low after exit", cpu_clk_en, 0);
        // R3: request during settling window is ignored
        mode_req_vld = 1; mode_req = 3'd1;
        tick();
        mode_req_vld = 0;
        check("R10", "reset req one cycle", sys_reset_req, 0);
        check("R3", "request while settling", pm_mode, 0);
        for (int k = 2; k < W; k++) tick();
        check("R5", "cpu still low", cpu_clk_en, 0);
        tick();
        check("R5", "cpu up after window", cpu_clk_en, 1);
        check("R10", "flag sticky", shutdown_exit, 1);
        go_mode(1);
        check("R10", "flag sticky after sleep", shutdown_exit, 1);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule